// File: doc/BRIEF.md
# Four-Hart Pipeline Stage Selectors

This block chooses, on every clock cycle, which hardware thread (hart) each of the five pipeline stages of a four-hart multithreaded core serves. The stages are fetch, decode/rename, issue, writeback and commit. Each stage has its own selector, and no selector looks at the choice of another. The pipeline around the block reports per-hart readiness flags: instruction buffer occupancy, reorder-buffer room, ready entries in the instruction table, result and commit buffer occupancy, the state of the oldest reorder-buffer entry, and the ending token passed from the preceding hart. The block answers with one one-hot grant vector per stage.

The core has no branch predictor. Any hart that has just fetched is therefore held back from fetching again until its next program counter has been resolved, either by decode or by branch resolution. The block tracks this hold-back per hart and drops it when the resolving unit raises a pulse. Every selector rotates its priority so that the hart granted last is the lowest-priority candidate next time. The interleaving of harts therefore follows only from the inputs and is fully repeatable.

Top module: `hart_stage_select`

## Requirements
- R1: In every cycle each of the five grant outputs has at most one bit set, and each stage decides from its own eligibility alone.
- R2: Hart h may be granted fetch only when pc_valid[h] is 1, hart h is not held back, and ib_full[h] is 0.
- R3: A fetch grant to hart h holds hart h back from the next clock edge on. It cannot fetch again until a cycle with npc_valid[h]=1 has been followed by a clock edge. The pulse does not release the hold-back in the cycle in which it is raised.
- R4: Hart h may be granted rename only when ib_full[h]=1, rob_room[h]=1 and the shared rename_free=1.
- R5: Hart h may be granted issue only when itab_ready[h]=1 and rbuf_full[h]=0.
- R6: Hart h may be granted writeback only when rbuf_full[h]=1 and cbuf_full[h]=0.
- R7: Hart h may be granted commit only when tail_done[h]=1. If tail_ending[h]=1, end_token[h] must also be 1.
- R8: Each selector grants the first eligible hart in the order last+1, last+2, and so on (modulo 4), where last is the hart it granted most recently. A cycle with no grant leaves last unchanged.
- R9: A stage with no eligible hart drives an all-zero grant vector.
- R10: Reset (rst_n=0) releases every hold-back and sets every selector's last to hart 3, so hart 0 has first priority after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_valid | input | 4 | Hart has a running thread |
| ib_full | input | 4 | One-entry instruction buffer of the hart is occupied |
| rename_free | input | 1 | A renaming register is available |
| rob_room | input | 4 | Reorder buffer of the hart has a free entry |
| itab_ready | input | 4 | Instruction table holds a ready instruction for the hart |
| rbuf_full | input | 4 | Result buffer of the hart is occupied |
| cbuf_full | input | 4 | Commit buffer of the hart is occupied |
| tail_done | input | 4 | Oldest reorder-buffer entry of the hart has finished |
| tail_ending | input | 4 | Oldest reorder-buffer entry of the hart ends the hart |
| end_token | input | 4 | Ending token from the predecessor hart has arrived |
| npc_valid | input | 4 | Next pc of the hart has been resolved (pulse) |
| gnt_fetch | output | 4 | One-hot fetch grant |
| gnt_rename | output | 4 | One-hot decode/rename grant |
| gnt_issue | output | 4 | One-hot issue grant |
| gnt_wb | output | 4 | One-hot writeback grant |
| gnt_commit | output | 4 | One-hot commit grant |

## Verification
A vector table drives rename, issue, writeback and commit through several patterns. These include all harts eligible, so that the rotating priority must advance one hart per grant. They also include partial eligibility, where the rotation has to skip a blocked hart, and single blockers such as a missing rename register, a full result buffer, or an ending instruction without its token. Directed fetch sequences keep every hart running until all four are held back. They then release single harts by pulses, which separates the pulse cycle from the following cycle and a buffer or pc_valid block from a suspension. A mid-run reset checks that all hold-backs are released and that priority returns to hart 0.

// File: rtl/hart_stage_select.sv
module hart_stage_select #(
  parameter int NH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NH-1:0] pc_valid,
  input  logic [NH-1:0] ib_full,
  input  logic          rename_free,
  input  logic [NH-1:0] rob_room,
  input  logic [NH-1:0] itab_ready,
  input  logic [NH-1:0] rbuf_full,
  input  logic [NH-1:0] cbuf_full,
  input  logic [NH-1:0] tail_done,
  input  logic [NH-1:0] tail_ending,
  input  logic [NH-1:0] end_token,
  input  logic [NH-1:0] npc_valid,
  output logic [NH-1:0] gnt_fetch,
  output logic [NH-1:0] gnt_rename,
  output logic [NH-1:0] gnt_issue,
  output logic [NH-1:0] gnt_wb,
  output logic [NH-1:0] gnt_commit
);

  localparam int NS = 5;
  localparam int IW = (NH > 1) ? $clog2(NH) : 1;
  localparam logic [IW-1:0] LAST0 = IW'(NH - 1);

  logic [NH-1:0] held_q;
  logic [NH-1:0] elig [NS];
  logic [NH-1:0] gnt  [NS];
  logic [IW-1:0] last_q [NS];

  function automatic logic [NH-1:0] rr_pick(input logic [NH-1:0] req, input logic [IW-1:0] last);
    rr_pick = '0;
    for (int k = NH; k >= 1; k--) begin
      int idx;
      idx = (int'(last) + k) % NH;
      if (req[idx]) rr_pick = {{(NH-1){1'b0}}, 1'b1} << idx;
    end
  endfunction

  function automatic logic [IW-1:0] enc(input logic [NH-1:0] oh);
    enc = '0;
    for (int k = 0; k < NH; k++)
      if (oh[k]) enc = IW'(k);
  endfunction

  assign elig[0] = pc_valid & ~held_q & ~ib_full;
  assign elig[1] = ib_full & rob_room & {NH{rename_free}};
  assign elig[2] = itab_ready & ~rbuf_full;
  assign elig[3] = rbuf_full & ~cbuf_full;
  assign elig[4] = tail_done & (~tail_ending | end_token);

  genvar s;
  generate
    for (s = 0; s < NS; s++) begin : g_stage
      assign gnt[s] = rr_pick(elig[s], last_q[s]);

      always_ff @(posedge clk) begin
        if (!rst_n)          last_q[s] <= LAST0;
        else if (|gnt[s])    last_q[s] <= enc(gnt[s]);
      end

      a_r1_one_grant: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt[s]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= (held_q & ~npc_valid) | gnt[0];
  end

  assign gnt_fetch  = gnt[0];
  assign gnt_rename = gnt[1];
  assign gnt_issue  = gnt[2];
  assign gnt_wb     = gnt[3];
  assign gnt_commit = gnt[4];

  genvar h;
  generate
    for (h = 0; h < NH; h++) begin : g_chk
      a_r3_no_refetch: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_fetch[h] |=> !gnt_fetch[h]);
      a_r2_fetch_ok: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_fetch[h] |-> pc_valid[h] && !ib_full[h]);
      a_r4_rename_ok: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_rename[h] |-> ib_full[h] && rob_room[h] && rename_free);
      a_r5_issue_ok: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_issue[h] |-> itab_ready[h] && !rbuf_full[h]);
      a_r6_wb_ok: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_wb[h] |-> rbuf_full[h] && !cbuf_full[h]);
      a_r7_end_token: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_commit[h] && tail_ending[h] |-> end_token[h] && tail_done[h]);
    end
  endgenerate

  a_r9_fetch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_valid == '0) |-> (gnt_fetch == '0));

endmodule

// File: tb/hart_stage_select_tb.sv
module hart_stage_select_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] pc_valid = '0, ib_full = '0, rob_room = '0, itab_ready = '0;
  logic [3:0] rbuf_full = '0, cbuf_full = '0, tail_done = '0, tail_ending = '0;
  logic [3:0] end_token = '0, npc_valid = '0;
  logic rename_free = 1'b0;
  logic [3:0] gnt_fetch, gnt_rename, gnt_issue, gnt_wb, gnt_commit;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hart_stage_select u_dut (
    .clk(clk), .rst_n(rst_n), .pc_valid(pc_valid), .ib_full(ib_full),
    .rename_free(rename_free), .rob_room(rob_room), .itab_ready(itab_ready),
    .rbuf_full(rbuf_full), .cbuf_full(cbuf_full), .tail_done(tail_done),
    .tail_ending(tail_ending), .end_token(end_token), .npc_valid(npc_valid),
    .gnt_fetch(gnt_fetch), .gnt_rename(gnt_rename), .gnt_issue(gnt_issue),
    .gnt_wb(gnt_wb), .gnt_commit(gnt_commit)
  );

  // {rename_free, ib, rob, itab, rbuf, cbuf, tdone, tend, tok, exp_ren, exp_iss, exp_wb, exp_com}
  localparam int NV = 8;
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0},
    {1'b1, 4'hF, 4'hF, 4'hF, 4'h0, 4'h0, 4'hF, 4'h0, 4'h0, 4'h1, 4'h1, 4'h0, 4'h1},
    {1'b1, 4'hF, 4'hF, 4'hF, 4'h5, 4'h0, 4'hF, 4'h0, 4'h0, 4'h2, 4'h2, 4'h1, 4'h2},
    {1'b1, 4'hF, 4'hB, 4'h0, 4'h5, 4'h4, 4'hF, 4'hF, 4'h4, 4'h8, 4'h0, 4'h1, 4'h4},
    {1'b0, 4'hF, 4'hF, 4'hF, 4'h0, 4'h0, 4'h9, 4'h1, 4'h0, 4'h0, 4'h4, 4'h0, 4'h8},
    {1'b1, 4'h0, 4'hF, 4'hF, 4'h0, 4'h0, 4'hF, 4'h0, 4'h0, 4'h0, 4'h8, 4'h0, 4'h1},
    {1'b1, 4'hF, 4'hF, 4'hF, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, 4'h1, 4'h0, 4'h2, 4'h0},
    {1'b1, 4'h6, 4'hF, 4'hF, 4'hF, 4'h2, 4'h0, 4'h0, 4'h0, 4'h2, 4'h0, 4'h4, 4'h0}
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic fstep(input logic [3:0] pv, input logic [3:0] ib, input logic [3:0] npc,
                       input logic [3:0] exp, input string req);
    @(negedge clk);
    pc_valid = pv; ib_full = ib; npc_valid = npc;
    #1 check(req, gnt_fetch, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R10 reset fetch idle", gnt_fetch, 4'h0);
    check("R9 reset rename idle", gnt_rename, 4'h0);
    check("R9 reset commit idle", gnt_commit, 4'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {rename_free, ib_full, rob_room, itab_ready, rbuf_full, cbuf_full,
       tail_done, tail_ending, end_token} = VEC[i][48:16];
      #1;
      check($sformatf("R4 R8 rename v%0d", i), gnt_rename, VEC[i][15:12]);
      check($sformatf("R5 R8 issue v%0d", i),  gnt_issue,  VEC[i][11:8]);
      check($sformatf("R6 R8 wb v%0d", i),     gnt_wb,     VEC[i][7:4]);
      check($sformatf("R7 R8 commit v%0d", i), gnt_commit, VEC[i][3:0]);
      check($sformatf("R1 R9 fetch idle v%0d", i), gnt_fetch, 4'h0);
    end

    @(negedge clk);
    {rename_free, ib_full, rob_room, itab_ready, rbuf_full, cbuf_full,
     tail_done, tail_ending, end_token} = '0;

    // fetch rotation and hold-back
    fstep(4'hF, 4'h0, 4'h0, 4'h1, "R2 R8 fetch h0");
    fstep(4'hF, 4'h0, 4'h0, 4'h2, "R3 R8 fetch h1");
    fstep(4'hF, 4'h0, 4'h0, 4'h4, "R3 R8 fetch h2");
    fstep(4'hF, 4'h0, 4'h0, 4'h8, "R3 R8 fetch h3");
    fstep(4'hF, 4'h0, 4'h0, 4'h0, "R3 R9 all held");
    fstep(4'hF, 4'h0, 4'h1, 4'h0, "R3 pulse cycle still held");
    fstep(4'hF, 4'h0, 4'h0, 4'h1, "R3 released h0");
    fstep(4'hF, 4'h0, 4'h2, 4'h0, "R3 h0 held again");
    fstep(4'hF, 4'h2, 4'h0, 4'h0, "R2 ib_full blocks h1");
    fstep(4'hF, 4'h0, 4'h0, 4'h2, "R2 h1 fetches");
    fstep(4'hF, 4'h0, 4'h4, 4'h0, "R3 pulse h2");
    fstep(4'hB, 4'h0, 4'h0, 4'h0, "R2 pc_valid blocks h2");
    fstep(4'hF, 4'h0, 4'h0, 4'h4, "R2 h2 fetches");

    // mid-run reset
    @(negedge clk);
    rst_n = 1'b0; pc_valid = 4'h0;
    @(negedge clk);
    rst_n = 1'b1;
    fstep(4'hF, 4'h0, 4'h0, 4'h1, "R10 release and priority h0");
    fstep(4'hF, 4'h0, 4'h0, 4'h2, "R10 R8 next h1");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule